// File: doc/BRIEF.md
# DDR SDRAM Command Timing Checker

A passive monitor that sits on the command bus of a four-bank DDR SDRAM and checks every command against the bank state machine and the minimum and maximum spacings the device demands. It samples clock enable, chip select, the three strobes, the bank-select bits and address bit 10 on each rising clock edge. It drives nothing on the bus. It keeps, for every bank, whether a row is open and how many cycles have passed since the bank was last opened and last closed. A few bus-wide spacing counters complete the state.

When a command breaks a rule, the monitor reports one violation. It raises a one-cycle error flag together with a small error code and the bank concerned. All limits are parameters counted in clock cycles, so one monitor instance can be set up for any speed grade. The monitor is meant for a simulation bench or an emulation build. Its outputs go to a scoreboard or a trigger.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset, and in every cycle whose command breaks no rule, err_valid, err_code and err_bank are all 0. Reset clears every bank to idle and every spacing history to "long ago".
- R2: A command exists only when cke=1 and cs_n=0. {ras_n,cas_n,we_n} = 011 is activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 NOP and 000 mode-register set. The bank index is {ba[1],ba[0]}, with ba[0] the low select bit. A command sampled at a rising edge is reported on the outputs right after that same edge.
- R3: Activating an open bank, or reading or writing an idle bank, gives code 3 (state). A command flagged this way changes no bank state.
- R4: A read or write issued fewer than T_RCD cycles after that bank's activate gives code 7. An activate issued fewer than T_RRD cycles after the previous activate to any bank gives code 6.
- R5: An activate issued fewer than T_RC cycles after the previous activate of the same bank gives code 4. An activate issued fewer than T_RP cycles after an explicit precharge closed that bank gives code 5.
- R6: A precharge that closes an open bank fewer than T_RAS cycles after its activate gives code 10. A precharge with a10=1 ignores ba and closes all open banks, and reports the lowest offending bank. In every cycle in which a bank has been open more than T_RAS_MAX cycles, the monitor reports code 11 for the lowest such bank.
- R7: A read or write with a10=1 closes its bank at once, so any further read or write to that bank gives code 3. The bank may be re-activated only BURST+T_RP cycles after a read of this kind, or BURST+T_WR+T_RP cycles after a write of this kind. An earlier activate gives code 5.
- R8: A mode-register set issued while any bank is open gives code 2, with the lowest open bank. An activate, read, write, precharge or mode-register set issued fewer than T_MRD cycles after a mode-register set gives code 1.
- R9: A read or write issued fewer than T_CCD cycles after the previous read or write gives code 8. A read issued fewer than BURST+T_WTR cycles after a write gives code 9.
- R10: When several rules break in one cycle, only the lowest code is reported (1 highest priority, 11 lowest).
- R11: NOP, burst stop and cycles with cke=0 or cs_n=1 never cause codes 1 to 10. Only code 11 can appear in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select, ba[0] low bit |
| a10 | input | 1 | Address bit 10: all-bank precharge / auto-precharge |
| err_valid | output | 1 | A violation was seen in the last sampled cycle |
| err_code | output | 4 | Violation code, 0 when none |
| err_bank | output | BA_W (2) | Bank of the reported violation, 0 when none |

## Verification
A single command stream drives each spacing rule once just inside and once just outside its limit. The just-inside case tells an off-by-one counter apart from a correct one. The stream covers single-bank and all-bank precharge, reads and writes with auto-precharge, and the mode-register window, with the bank state left in a known condition each time. Burst stop, NOP and a cycle with clock enable low carrying an activate pattern then show that none of them moves the bank state. Directed steps let an open row age past its maximum, reset the monitor in mid-traffic, and break three rules at once to expose the priority order.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  // decoded bus command; C_IDLE means nothing was issued this cycle
  typedef enum logic [2:0] {
    C_IDLE, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_BST, C_MRS
  } cmd_e;

  // violation codes: a smaller value wins when several apply
  typedef enum logic [3:0] {
    E_NONE     = 4'd0,
    E_MRD      = 4'd1,
    E_MRS_OPEN = 4'd2,
    E_STATE    = 4'd3,
    E_RC       = 4'd4,
    E_RP       = 4'd5,
    E_RRD      = 4'd6,
    E_RCD      = 4'd7,
    E_CCD      = 4'd8,
    E_WTR      = 4'd9,
    E_RAS_MIN  = 4'd10,
    E_RAS_MAX  = 4'd11
  } err_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = C_IDLE;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b110:  cmd = C_BST;
        3'b111:  cmd = C_NOP;
        3'b000:  cmd = C_MRS;
        default: cmd = C_IDLE;  // refresh and others are not checked
      endcase
    end
  end

endmodule

// File: rtl/ddr_gap_counter.sv
// Counts cycles since the last restart; saturates at all ones, which
// also stands for "never" after reset.
module ddr_gap_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] gap
);

  always_ff @(posedge clk) begin
    if (rst)
      gap <= '1;
    else if (restart)
      gap <= CW'(1);
    else if (gap != '1)
      gap <= gap + 1'b1;
  end

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open_i,
  input  logic          close_i,
  input  logic [CW-1:0] need_i,
  output logic          active_o,
  output logic [CW-1:0] act_gap_o,
  output logic [CW-1:0] close_gap_o,
  output logic [CW-1:0] need_o
);

  ddr_gap_counter #(.CW(CW)) u_act (
    .clk     (clk),
    .rst     (rst),
    .restart (open_i),
    .gap     (act_gap_o)
  );

  ddr_gap_counter #(.CW(CW)) u_cls (
    .clk     (clk),
    .rst     (rst),
    .restart (close_i),
    .gap     (close_gap_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      need_o   <= '0;
    end else begin
      if (open_i)
        active_o <= 1'b1;
      else if (close_i)
        active_o <= 1'b0;
      if (close_i)
        need_o <= need_i;
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RAS_MAX = 16000,
  parameter int T_RC      = 9,
  parameter int T_WR      = 2,
  parameter int T_MRD     = 2,
  parameter int T_WTR     = 1,
  parameter int T_CCD     = 1,
  parameter int BURST     = 2,
  localparam int BA_W     = $clog2(NBANK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            err_valid,
  output logic [3:0]      err_code,
  output logic [BA_W-1:0] err_bank
);

  localparam int CW = $clog2(T_RAS_MAX + 2) + 1;
  localparam logic [CW-1:0] L_RCD     = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP      = CW'(T_RP);
  localparam logic [CW-1:0] L_RRD     = CW'(T_RRD);
  localparam logic [CW-1:0] L_RAS     = CW'(T_RAS);
  localparam logic [CW-1:0] L_RAS_MAX = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] L_RC      = CW'(T_RC);
  localparam logic [CW-1:0] L_MRD     = CW'(T_MRD);
  localparam logic [CW-1:0] L_CCD     = CW'(T_CCD);
  localparam logic [CW-1:0] L_RD2WR   = CW'(BURST + T_WTR);
  localparam logic [CW-1:0] L_RDAP    = CW'(BURST + T_RP);
  localparam logic [CW-1:0] L_WRAP    = CW'(BURST + T_WR + T_RP);

  function automatic logic [BA_W-1:0] lowest(input logic [NBANK-1:0] v);
    lowest = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (v[i]) lowest = BA_W'(i);
  endfunction

  // ---------------------------------------------------------------- decode
  cmd_e cmd;

  ddr_cmd_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  logic is_col;
  assign is_col = (cmd == C_RD) || (cmd == C_WR);

  // ---------------------------------------------------------------- banks
  logic [NBANK-1:0] sel, active, open_b, close_b;
  logic [NBANK-1:0] ras_min_hit, ras_max_hit;
  logic [CW-1:0]    act_gap   [NBANK];
  logic [CW-1:0]    close_gap [NBANK];
  logic [CW-1:0]    need      [NBANK];
  logic [CW-1:0]    close_need;

  always_comb begin
    if (cmd == C_RD)      close_need = L_RDAP;
    else if (cmd == C_WR) close_need = L_WRAP;
    else                  close_need = L_RP;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign sel[b]    = (ba == BA_W'(b));
    assign open_b[b] = (cmd == C_ACT) && sel[b] && !active[b];
    assign close_b[b] = active[b] &&
                        (((cmd == C_PRE) && (a10 || sel[b])) ||
                         (is_col && a10 && sel[b]));

    assign ras_min_hit[b] = active[b] && (cmd == C_PRE) && (a10 || sel[b]) &&
                            (act_gap[b] < L_RAS);
    assign ras_max_hit[b] = active[b] && (act_gap[b] > L_RAS_MAX);

    ddr_bank_timer #(.CW(CW)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .open_i      (open_b[b]),
      .close_i     (close_b[b]),
      .need_i      (close_need),
      .active_o    (active[b]),
      .act_gap_o   (act_gap[b]),
      .close_gap_o (close_gap[b]),
      .need_o      (need[b])
    );
  end

  // ---------------------------------------------------------------- bus-wide spacing
  logic [CW-1:0] any_act_gap, col_gap, wr_gap, mrs_gap;

  ddr_gap_counter #(.CW(CW)) u_any_act (
    .clk (clk), .rst (rst), .restart (|open_b), .gap (any_act_gap)
  );
  ddr_gap_counter #(.CW(CW)) u_col (
    .clk (clk), .rst (rst), .restart (is_col && active[ba]), .gap (col_gap)
  );
  ddr_gap_counter #(.CW(CW)) u_wr (
    .clk (clk), .rst (rst), .restart ((cmd == C_WR) && active[ba]), .gap (wr_gap)
  );
  ddr_gap_counter #(.CW(CW)) u_mrs (
    .clk (clk), .rst (rst), .restart (cmd == C_MRS), .gap (mrs_gap)
  );

  // ---------------------------------------------------------------- rule checks
  logic chk_mrd, chk_mrs_open, chk_state, chk_rc, chk_rp, chk_rrd;
  logic chk_rcd, chk_ccd, chk_wtr;
  logic mrd_cmd;

  assign mrd_cmd      = (cmd == C_ACT) || is_col || (cmd == C_PRE) || (cmd == C_MRS);
  assign chk_mrd      = mrd_cmd && (mrs_gap < L_MRD);
  assign chk_mrs_open = (cmd == C_MRS) && (|active);
  assign chk_state    = ((cmd == C_ACT) && active[ba]) || (is_col && !active[ba]);
  assign chk_rc       = (cmd == C_ACT) && (act_gap[ba] < L_RC);
  assign chk_rp       = (cmd == C_ACT) && (close_gap[ba] < need[ba]);
  assign chk_rrd      = (cmd == C_ACT) && (any_act_gap < L_RRD);
  assign chk_rcd      = is_col && (act_gap[ba] < L_RCD);
  assign chk_ccd      = is_col && (col_gap < L_CCD);
  assign chk_wtr      = (cmd == C_RD) && (wr_gap < L_RD2WR);

  err_e            code_n;
  logic [BA_W-1:0] bank_n;

  always_comb begin
    code_n = E_NONE;
    bank_n = ba;
    if (chk_mrd)                code_n = E_MRD;
    else if (chk_mrs_open) begin
      code_n = E_MRS_OPEN;
      bank_n = lowest(active);
    end
    else if (chk_state)         code_n = E_STATE;
    else if (chk_rc)            code_n = E_RC;
    else if (chk_rp)            code_n = E_RP;
    else if (chk_rrd)           code_n = E_RRD;
    else if (chk_rcd)           code_n = E_RCD;
    else if (chk_ccd)           code_n = E_CCD;
    else if (chk_wtr)           code_n = E_WTR;
    else if (|ras_min_hit) begin
      code_n = E_RAS_MIN;
      bank_n = lowest(ras_min_hit);
    end
    else if (|ras_max_hit) begin
      code_n = E_RAS_MAX;
      bank_n = lowest(ras_max_hit);
    end
    if (code_n == E_NONE)
      bank_n = '0;
  end

  // ---------------------------------------------------------------- registered report
  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
      err_bank  <= '0;
    end else begin
      err_valid <= (code_n != E_NONE);
      err_code  <= code_n;
      err_bank  <= bank_n;
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor_sva.sv
module ddr_cmd_monitor_sva
  import ddr_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_MRD = 2,
  parameter int T_CCD = 1
) (
  input logic            clk,
  input logic            rst,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            a10,
  input logic            err_valid,
  input logic [3:0]      err_code,
  input logic [BA_W-1:0] err_bank
);

  logic live, is_act, is_rd, is_wr, is_mrs, is_col;
  assign live   = cke && !cs_n;
  assign is_act = live && ({ras_n, cas_n, we_n} == 3'b011);
  assign is_rd  = live && ({ras_n, cas_n, we_n} == 3'b101);
  assign is_wr  = live && ({ras_n, cas_n, we_n} == 3'b100);
  assign is_mrs = live && ({ras_n, cas_n, we_n} == 3'b000);
  assign is_col = is_rd || is_wr;

  logic            act_q, col_q, mrs_q, rdap_q;
  logic [BA_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      col_q  <= 1'b0;
      mrs_q  <= 1'b0;
      rdap_q <= 1'b0;
      bank_q <= '0;
    end else begin
      act_q  <= is_act;
      col_q  <= is_col;
      mrs_q  <= is_mrs;
      rdap_q <= is_rd && a10;
      bank_q <= ba;
    end
  end

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> (err_code == 4'd0 && err_bank == '0));  // R1

  AST_IDLE_BENIGN: assert property (@(posedge clk) disable iff (rst)
    !live |=> (!err_valid || err_code == E_RAS_MAX));  // R11

  AST_DOUBLE_ACT: assert property (@(posedge clk) disable iff (rst)
    act_q && is_act && ba == bank_q |=> err_valid);  // R3

  AST_AP_READ_CLOSES: assert property (@(posedge clk) disable iff (rst)
    rdap_q && is_col && ba == bank_q |=> err_valid);  // R7

  if (T_MRD >= 2) begin : g_mrd
    AST_MRS_WINDOW: assert property (@(posedge clk) disable iff (rst)
      mrs_q && is_act |=> (err_valid && err_code == E_MRD));  // R8
  end

  if (T_CCD >= 2) begin : g_ccd
    AST_COL_SPACING: assert property (@(posedge clk) disable iff (rst)
      col_q && is_col && ba == bank_q |=> err_valid);  // R9
  end

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_sva #(
  .BA_W  (BA_W),
  .T_MRD (T_MRD),
  .T_CCD (T_CCD)
) u_sva (.*);

// File: tb/sim_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module sim_ddr_cmd_monitor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       err_valid;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_monitor #(
    .T_RCD (3), .T_RP (3), .T_RRD (2), .T_RAS (6), .T_RAS_MAX (40),
    .T_RC (9), .T_WR (2), .T_MRD (2), .T_WTR (1), .T_CCD (2), .BURST (2)
  ) u0 (
    .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .a10 (a10),
    .err_valid (err_valid), .err_code (err_code), .err_bank (err_bank)
  );

  // pin patterns {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_BST = 4'b0110, P_NOP = 4'b0111,
                         P_MRS = 4'b0000;

  typedef struct packed {
    logic        ck;
    logic [3:0]  pins;
    logic [1:0]  b;
    logic        ap;
    logic [3:0]  code;
    logic [1:0]  bank;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t TBL [NV] = '{
    '{1'b1, P_ACT, 2'd0, 1'b0, 4'd0,  2'd0, "R4 "},  // 0
    '{1'b1, P_ACT, 2'd1, 1'b0, 4'd6,  2'd1, "R4 "},  // 1 tRRD
    '{1'b1, P_RD,  2'd0, 1'b0, 4'd7,  2'd0, "R4 "},  // 2 tRCD
    '{1'b1, P_RD,  2'd0, 1'b0, 4'd8,  2'd0, "R9 "},  // 3 tCCD
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 4
    '{1'b1, P_WR,  2'd1, 1'b0, 4'd0,  2'd0, "R9 "},  // 5
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 6
    '{1'b1, P_RD,  2'd1, 1'b0, 4'd9,  2'd1, "R9 "},  // 7 tWTR
    '{1'b1, P_PRE, 2'd0, 1'b0, 4'd0,  2'd0, "R6 "},  // 8
    '{1'b1, P_ACT, 2'd0, 1'b0, 4'd5,  2'd0, "R5 "},  // 9 tRP
    '{1'b1, P_PRE, 2'd0, 1'b0, 4'd10, 2'd0, "R6 "},  // 10 tRAS min
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 11
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 12
    '{1'b1, P_ACT, 2'd0, 1'b0, 4'd4,  2'd0, "R5 "},  // 13 tRC
    '{1'b1, P_RD,  2'd2, 1'b0, 4'd3,  2'd2, "R3 "},  // 14 read idle
    '{1'b1, P_ACT, 2'd1, 1'b0, 4'd3,  2'd1, "R3 "},  // 15 act open
    '{1'b1, P_MRS, 2'd0, 1'b0, 4'd2,  2'd0, "R8 "},  // 16 MRS open
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R8 "},  // 17
    '{1'b1, P_PRE, 2'd3, 1'b1, 4'd10, 2'd0, "R6 "},  // 18 all-bank
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 19
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 20
    '{1'b1, P_ACT, 2'd2, 1'b0, 4'd0,  2'd0, "R2 "},  // 21
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 22
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 23
    '{1'b1, P_WR,  2'd2, 1'b1, 4'd0,  2'd0, "R7 "},  // 24 write AP
    '{1'b1, P_WR,  2'd2, 1'b0, 4'd3,  2'd2, "R7 "},  // 25
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 26
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 27
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 28
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 29
    '{1'b1, P_ACT, 2'd2, 1'b0, 4'd5,  2'd2, "R7 "},  // 30 6 < 7
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 31
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 32
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 33
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 34
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 35
    '{1'b1, P_PRE, 2'd2, 1'b0, 4'd0,  2'd0, "R6 "},  // 36
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 37
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 38
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 39
    '{1'b1, P_MRS, 2'd0, 1'b0, 4'd0,  2'd0, "R8 "},  // 40
    '{1'b1, P_ACT, 2'd3, 1'b0, 4'd1,  2'd3, "R8 "},  // 41 tMRD
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 42
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 43
    '{1'b1, P_RD,  2'd3, 1'b1, 4'd0,  2'd0, "R7 "},  // 44 read AP
    '{1'b1, P_RD,  2'd3, 1'b0, 4'd3,  2'd3, "R7 "},  // 45
    '{1'b1, P_BST, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 46
    '{1'b0, P_ACT, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 47 cke low
    '{1'b1, P_RD,  2'd0, 1'b0, 4'd3,  2'd0, "R2 "},  // 48 act ignored
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R11"},  // 49
    '{1'b1, P_ACT, 2'd3, 1'b0, 4'd0,  2'd0, "R7 "},  // 50 5 <= 6
    '{1'b1, P_NOP, 2'd0, 1'b0, 4'd0,  2'd0, "R1 "}   // 51
  };

  task automatic check(input logic [3:0] ec, input logic [1:0] eb, input logic [23:0] tag);
    n_run++;
    if (err_valid !== (ec != 4'd0) || err_code !== ec || err_bank !== eb) begin
      n_fail++;
      $display("FAIL %s: got valid=%b code=%0d bank=%0d, expected valid=%b code=%0d bank=%0d",
               tag, err_valid, err_code, err_bank, (ec != 4'd0), ec, eb);
    end
  endtask

  task automatic issue(input logic ck, input logic [3:0] pins, input logic [1:0] b,
                       input logic ap);
    @(negedge clk);
    cke = ck;
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba  = b;
    a10 = ap;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(4'd0, 2'd0, "R1 ");
    @(negedge clk);
    rst = 1'b0;

    // stimulus table, one command per cycle
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].ck, TBL[i].pins, TBL[i].b, TBL[i].ap);
      check(TBL[i].code, TBL[i].bank, TBL[i].tag);
    end

    // R6: bank 3 opened at entry 50; open too long once the gap exceeds 40
    for (int g = 2; g <= 41; g++) begin
      issue(1'b1, P_NOP, 2'd0, 1'b0);
      if (g == 40) check(4'd0, 2'd0, "R6 ");
      if (g == 41) check(4'd11, 2'd3, "R6 ");
    end
    issue(1'b1, P_PRE, 2'd3, 1'b0);
    issue(1'b1, P_NOP, 2'd0, 1'b0);
    check(4'd0, 2'd0, "R6 ");

    // R1: reset in mid-traffic clears bank state
    issue(1'b1, P_ACT, 2'd3, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    repeat (2) @(posedge clk);
    #1;
    check(4'd0, 2'd0, "R1 ");
    @(negedge clk);
    rst = 1'b0;
    issue(1'b1, P_RD, 2'd3, 1'b0);
    check(4'd3, 2'd3, "R3 ");

    // R10: state, tRC and tRRD all break; state wins
    issue(1'b1, P_ACT, 2'd1, 1'b0);
    check(4'd0, 2'd0, "R10");
    issue(1'b1, P_ACT, 2'd1, 1'b0);
    check(4'd3, 2'd1, "R10");
    issue(1'b1, P_NOP, 2'd0, 1'b0);
    check(4'd0, 2'd0, "R11");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule